// File: doc/BRIEF.md
# Deferred-Fault Register File

This block is a small register file for an execution pipeline that runs some instructions ahead of the branches that guard them. Each entry holds a data word and a one-bit fault tag. When a speculative instruction faults, no trap is taken. The destination is tagged and loaded with the instruction's PC. Speculative instructions that consume a tagged value pass the tag and the stored PC on to their own destinations. A trap is raised only when a non-speculative instruction reads a tagged entry, or when a non-speculative instruction faults by itself.

At writeback the block receives the following: a valid strobe, the speculative bit, the PC, two source indices, the destination index, a fault flag from the execution unit and the result. It looks up the tags of the two sources and then does one of two things. It writes the destination, or it issues a trap request that carries the PC of the original faulting instruction. Two read ports give the operands to the issue stage. These ports forward the entry that is being written in the same cycle.

Top module: `spec_rf`

## Requirements
- R1: While `rst_ni` is low, every entry is cleared to data 0 with tag 0, and `exc_req_o` is 0.
- R2: A speculative writeback whose two sources have tag 0 and whose fault flag is 0 writes the result to the destination and sets its tag to 0. No trap is requested.
- R3: A speculative writeback whose two sources have tag 0 and whose fault flag is 1 sets the destination tag to 1 and loads the destination with `wb_pc_i`. No trap is requested.
- R4: A speculative writeback that reads a source with tag 1 sets the destination tag to 1 and copies that source's data into the destination. The instruction's own fault flag and result have no effect, and no trap is requested.
- R5: A non-speculative writeback that reads a source with tag 1 raises `exc_req_o`. `exc_pc_o` equals that source's data, and the destination entry keeps its previous data and tag.
- R6: A non-speculative writeback whose two sources have tag 0 and whose fault flag is 1 raises `exc_req_o` with `exc_pc_o` equal to `wb_pc_i`. The destination is not written.
- R7: When both sources have tag 1, source A (`wb_src_a_i`) supplies the PC that is copied by R4 or reported by R5.
- R8: Entry 0 always reads as data 0 with tag 0. Writebacks aimed at entry 0 have no effect.
- R9: A read port whose index matches the destination of the valid writeback in the same cycle returns the data and tag being written. Entry 0 is not forwarded.
- R10: A non-speculative writeback whose two sources have tag 0 and whose fault flag is 0 writes the result to the destination and sets its tag to 0. This also clears a tag that was set earlier.
- R11: `exc_req_o` is high for exactly the one cycle after each trapping writeback and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | IDX_W | Read port A index |
| rd_b_idx_i | input | IDX_W | Read port B index |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_a_tag_o | output | 1 | Read port A fault tag |
| rd_b_data_o | output | DATA_W | Read port B data |
| rd_b_tag_o | output | 1 | Read port B fault tag |
| wb_valid_i | input | 1 | Writeback valid |
| wb_spec_i | input | 1 | Writeback instruction is speculative |
| wb_pc_i | input | DATA_W | PC of the writeback instruction |
| wb_src_a_i | input | IDX_W | First source index (priority source) |
| wb_src_b_i | input | IDX_W | Second source index |
| wb_dst_i | input | IDX_W | Destination index |
| wb_fault_i | input | 1 | Fault flag from the execution unit |
| wb_result_i | input | DATA_W | Computed result |
| exc_req_o | output | 1 | Trap request, one cycle |
| exc_pc_o | output | DATA_W | PC reported with the trap |

## Verification
The bench uses the default build: 32-bit data and 16 entries. With this build, PCs and results wide enough to tell apart can be used, and every entry can be read back after reset. There are enough spare entries to build a tag chain through two speculative hops and to hold two tagged entries with different PCs. The two-tagged case shows which source wins, because the two entries carry different PCs. Forwarding is checked at the read ports for a clean write and for a tagged write, in the same cycle as the writeback.

// File: rtl/spec_rf_pkg.sv
`timescale 1ns/1ps
package spec_rf_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_WRITE,
    ACT_TAG_OWN,
    ACT_TAG_SRC,
    ACT_TRAP
  } wb_act_e;
endpackage

// File: rtl/spec_rf_array.sv
`timescale 1ns/1ps
module spec_rf_array #(
  parameter int DATA_W = 32,
  parameter int NREGS = 16,
  parameter int NRD = 4,
  parameter logic [NRD-1:0] BYPASS_MASK = '0,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wdst_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        wtag_i,
  input  logic [NRD-1:0][IDX_W-1:0]   raddr_i,
  output logic [NRD-1:0][DATA_W-1:0]  rdata_o,
  output logic [NRD-1:0]              rtag_o
);
  logic [DATA_W-1:0] mem_q [NREGS];
  logic [NREGS-1:0]  tag_q;
  logic              wr_en;

  assign wr_en = we_i && (wdst_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
      tag_q <= '0;
    end else if (wr_en) begin
      mem_q[wdst_i] <= wdata_i;
      tag_q[wdst_i] <= wtag_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    if (BYPASS_MASK[p]) begin : g_byp
      always_comb begin
        if (raddr_i[p] == '0) begin
          rdata_o[p] = '0;
          rtag_o[p]  = 1'b0;
        end else if (wr_en && (wdst_i == raddr_i[p])) begin
          rdata_o[p] = wdata_i;
          rtag_o[p]  = wtag_i;
        end else begin
          rdata_o[p] = mem_q[raddr_i[p]];
          rtag_o[p]  = tag_q[raddr_i[p]];
        end
      end
    end else begin : g_raw
      // source lookup path: no forwarding, avoids a loop through resolve
      always_comb begin
        if (raddr_i[p] == '0) begin
          rdata_o[p] = '0;
          rtag_o[p]  = 1'b0;
        end else begin
          rdata_o[p] = mem_q[raddr_i[p]];
          rtag_o[p]  = tag_q[raddr_i[p]];
        end
      end
    end
  end
endmodule

// File: rtl/spec_rf_resolve.sv
`timescale 1ns/1ps
module spec_rf_resolve
  import spec_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  logic              spec_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              tag_a_i,
  input  logic [DATA_W-1:0] dat_a_i,
  input  logic              tag_b_i,
  input  logic [DATA_W-1:0] dat_b_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wtag_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] trap_pc_o
);
  wb_act_e           act;
  logic              src_tagged;
  logic [DATA_W-1:0] src_pc;

  assign src_tagged = tag_a_i || tag_b_i;
  assign src_pc     = tag_a_i ? dat_a_i : dat_b_i; // port A wins

  always_comb begin
    if (!valid_i)                      act = ACT_IDLE;
    else if (spec_i && src_tagged)     act = ACT_TAG_SRC;
    else if (spec_i && fault_i)        act = ACT_TAG_OWN;
    else if (spec_i)                   act = ACT_WRITE;
    else if (src_tagged || fault_i)    act = ACT_TRAP;
    else                               act = ACT_WRITE;
  end

  always_comb begin
    we_o      = 1'b0;
    wdata_o   = result_i;
    wtag_o    = 1'b0;
    trap_o    = 1'b0;
    trap_pc_o = pc_i;
    unique case (act)
      ACT_WRITE:   we_o = 1'b1;
      ACT_TAG_OWN: begin we_o = 1'b1; wdata_o = pc_i;   wtag_o = 1'b1; end
      ACT_TAG_SRC: begin we_o = 1'b1; wdata_o = src_pc; wtag_o = 1'b1; end
      ACT_TRAP:    begin trap_o = 1'b1; trap_pc_o = src_tagged ? src_pc : pc_i; end
      default:     we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spec_rf.sv
`timescale 1ns/1ps
module spec_rf #(
  parameter int DATA_W = 32,
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic              rd_a_tag_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              rd_b_tag_o,
  input  logic              wb_valid_i,
  input  logic              wb_spec_i,
  input  logic [DATA_W-1:0] wb_pc_i,
  input  logic [IDX_W-1:0]  wb_src_a_i,
  input  logic [IDX_W-1:0]  wb_src_b_i,
  input  logic [IDX_W-1:0]  wb_dst_i,
  input  logic              wb_fault_i,
  input  logic [DATA_W-1:0] wb_result_i,
  output logic              exc_req_o,
  output logic [DATA_W-1:0] exc_pc_o
);
  localparam int NRD = 4; // 0,1: source lookup; 2,3: issue ports

  logic [NRD-1:0][IDX_W-1:0]  raddr;
  logic [NRD-1:0][DATA_W-1:0] rdata;
  logic [NRD-1:0]             rtag;
  logic                       we;
  logic [DATA_W-1:0]          wdata;
  logic                       wtag;
  logic                       trap;
  logic [DATA_W-1:0]          trap_pc;
  logic                       exc_req_q;
  logic [DATA_W-1:0]          exc_pc_q;

  assign raddr = {rd_b_idx_i, rd_a_idx_i, wb_src_b_i, wb_src_a_i};

  spec_rf_array #(
    .DATA_W(DATA_W),
    .NREGS(NREGS),
    .NRD(NRD),
    .BYPASS_MASK(4'b1100)
  ) u_array (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .we_i(we),
    .wdst_i(wb_dst_i),
    .wdata_i(wdata),
    .wtag_i(wtag),
    .raddr_i(raddr),
    .rdata_o(rdata),
    .rtag_o(rtag)
  );

  spec_rf_resolve #(.DATA_W(DATA_W)) u_resolve (
    .valid_i(wb_valid_i),
    .spec_i(wb_spec_i),
    .fault_i(wb_fault_i),
    .pc_i(wb_pc_i),
    .result_i(wb_result_i),
    .tag_a_i(rtag[0]),
    .dat_a_i(rdata[0]),
    .tag_b_i(rtag[1]),
    .dat_b_i(rdata[1]),
    .we_o(we),
    .wdata_o(wdata),
    .wtag_o(wtag),
    .trap_o(trap),
    .trap_pc_o(trap_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_req_q <= 1'b0;
      exc_pc_q  <= '0;
    end else begin
      exc_req_q <= trap;
      if (trap) exc_pc_q <= trap_pc;
    end
  end

  assign exc_req_o   = exc_req_q;
  assign exc_pc_o    = exc_pc_q;
  assign rd_a_data_o = rdata[2];
  assign rd_a_tag_o  = rtag[2];
  assign rd_b_data_o = rdata[3];
  assign rd_b_tag_o  = rtag[3];
endmodule

// File: rtl/spec_rf_chk.sv
`timescale 1ns/1ps
module spec_rf_chk #(
  parameter int DATA_W = 32,
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rd_a_idx_i,
  input logic [IDX_W-1:0]  rd_b_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic              rd_a_tag_o,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              rd_b_tag_o,
  input logic              wb_valid_i,
  input logic              wb_spec_i,
  input logic [DATA_W-1:0] wb_pc_i,
  input logic [IDX_W-1:0]  wb_src_a_i,
  input logic [IDX_W-1:0]  wb_src_b_i,
  input logic [IDX_W-1:0]  wb_dst_i,
  input logic              wb_fault_i,
  input logic [DATA_W-1:0] wb_result_i,
  input logic              exc_req_o,
  input logic [DATA_W-1:0] exc_pc_o
);
  AST_R0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == '0) |-> (rd_a_data_o == '0 && !rd_a_tag_o)); // R8

  AST_SPEC_NEVER_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_spec_i) |=> !exc_req_o); // R3

  AST_TRAP_NEEDS_NONSPEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(wb_valid_i && !wb_spec_i)); // R11

  AST_OWN_FAULT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !wb_spec_i && wb_fault_i && wb_src_a_i == '0 && wb_src_b_i == '0)
    |=> (exc_req_o && exc_pc_o == $past(wb_pc_i))); // R6

  AST_FORWARD_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_spec_i && !wb_fault_i && wb_src_a_i == '0 && wb_src_b_i == '0
     && wb_dst_i != '0 && rd_b_idx_i == wb_dst_i)
    |-> (rd_b_data_o == wb_result_i && !rd_b_tag_o)); // R9
endmodule

bind spec_rf spec_rf_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) u_chk (.*);

// File: tb/sim_spec_rf.sv
`timescale 1ns/1ps
module sim_spec_rf;
  localparam int DW = 32;
  localparam int NR = 16;
  localparam int IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          rd_a_tag, rd_b_tag;
  logic          wb_valid = 1'b0, wb_spec = 1'b0, wb_fault = 1'b0;
  logic [DW-1:0] wb_pc = '0, wb_result = '0;
  logic [IW-1:0] wb_src_a = '0, wb_src_b = '0, wb_dst = '0;
  logic          exc_req;
  logic [DW-1:0] exc_pc;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spec_rf #(.DATA_W(DW), .NREGS(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_b_idx_i(rd_b_idx),
    .rd_a_data_o(rd_a_data), .rd_a_tag_o(rd_a_tag),
    .rd_b_data_o(rd_b_data), .rd_b_tag_o(rd_b_tag),
    .wb_valid_i(wb_valid), .wb_spec_i(wb_spec), .wb_pc_i(wb_pc),
    .wb_src_a_i(wb_src_a), .wb_src_b_i(wb_src_b), .wb_dst_i(wb_dst),
    .wb_fault_i(wb_fault), .wb_result_i(wb_result),
    .exc_req_o(exc_req), .exc_pc_o(exc_pc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // read one entry on both ports, with no writeback active
  task automatic read_reg(input string req, input logic [IW-1:0] idx,
                          input logic [DW-1:0] exp_d, input logic exp_t);
    rd_a_idx = idx;
    rd_b_idx = idx;
    #1;
    check(req, {rd_a_tag, rd_a_data}, {exp_t, exp_d});
    check(req, {rd_b_tag, rd_b_data}, {exp_t, exp_d});
  endtask

  // one writeback; returns at the next falling edge, when exc_req reflects it
  task automatic do_wb(input logic spec, input logic [DW-1:0] pc,
                       input logic [IW-1:0] sa, input logic [IW-1:0] sb,
                       input logic fault, input logic [DW-1:0] res,
                       input logic [IW-1:0] dst);
    @(negedge clk);
    wb_spec = spec; wb_pc = pc; wb_src_a = sa; wb_src_b = sb;
    wb_fault = fault; wb_result = res; wb_dst = dst; wb_valid = 1'b1;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NR; i++) read_reg("R1 reset entry", IW'(i), '0, 1'b0);
    check("R1 reset exc_req", {63'd0, exc_req}, 64'd0);
  endtask

  task automatic t_spec_clean();
    do_wb(1'b1, 32'h100, 4'd0, 4'd0, 1'b0, 32'hAAAA_5555, 4'd1);
    check("R2 no trap", {63'd0, exc_req}, 64'd0);
    read_reg("R2 written", 4'd1, 32'hAAAA_5555, 1'b0);
  endtask

  task automatic t_nonspec_clean();
    do_wb(1'b0, 32'h110, 4'd1, 4'd0, 1'b0, 32'h1234, 4'd2);
    check("R10 no trap", {63'd0, exc_req}, 64'd0);
    read_reg("R10 written", 4'd2, 32'h1234, 1'b0);
  endtask

  task automatic t_spec_fault();
    do_wb(1'b1, 32'h200, 4'd0, 4'd0, 1'b1, 32'hBAD, 4'd3);
    check("R3 no trap", {63'd0, exc_req}, 64'd0);
    read_reg("R3 tagged own pc", 4'd3, 32'h200, 1'b1);
  endtask

  task automatic t_propagate();
    do_wb(1'b1, 32'h300, 4'd3, 4'd1, 1'b1, 32'h55, 4'd4);
    check("R4 no trap", {63'd0, exc_req}, 64'd0);
    read_reg("R4 copy via A", 4'd4, 32'h200, 1'b1);
    do_wb(1'b1, 32'h310, 4'd1, 4'd4, 1'b0, 32'h66, 4'd5);
    read_reg("R4 copy via B", 4'd5, 32'h200, 1'b1);
  endtask

  task automatic t_priority();
    do_wb(1'b1, 32'h600, 4'd0, 4'd0, 1'b1, 32'h0, 4'd6);
    do_wb(1'b1, 32'h610, 4'd6, 4'd3, 1'b0, 32'h77, 4'd7);
    read_reg("R7 spec takes A", 4'd7, 32'h600, 1'b1);
    do_wb(1'b0, 32'h620, 4'd3, 4'd6, 1'b0, 32'h88, 4'd2);
    check("R7 trap raised", {63'd0, exc_req}, 64'd1);
    check("R7 trap reports A", {32'd0, exc_pc}, {32'd0, 32'h200});
  endtask

  task automatic t_nonspec_tagged();
    do_wb(1'b0, 32'h700, 4'd1, 4'd4, 1'b0, 32'h99, 4'd2);
    check("R5 trap raised", {63'd0, exc_req}, 64'd1);
    check("R5 trap pc", {32'd0, exc_pc}, {32'd0, 32'h200});
    @(negedge clk);
    check("R11 trap one cycle", {63'd0, exc_req}, 64'd0);
    read_reg("R5 dst untouched", 4'd2, 32'h1234, 1'b0);
  endtask

  task automatic t_nonspec_fault();
    do_wb(1'b0, 32'h800, 4'd0, 4'd0, 1'b1, 32'hCAFE, 4'd1);
    check("R6 trap raised", {63'd0, exc_req}, 64'd1);
    check("R6 trap own pc", {32'd0, exc_pc}, {32'd0, 32'h800});
    read_reg("R6 dst untouched", 4'd1, 32'hAAAA_5555, 1'b0);
    @(negedge clk);
    check("R11 low after trap", {63'd0, exc_req}, 64'd0);
  endtask

  task automatic t_clear_tag();
    do_wb(1'b0, 32'h880, 4'd0, 4'd0, 1'b0, 32'h42, 4'd3);
    check("R10 no trap", {63'd0, exc_req}, 64'd0);
    read_reg("R10 tag cleared", 4'd3, 32'h42, 1'b0);
  endtask

  task automatic t_reg0();
    do_wb(1'b1, 32'h900, 4'd0, 4'd0, 1'b0, 32'hDEAD, 4'd0);
    read_reg("R8 clean write ignored", 4'd0, '0, 1'b0);
    do_wb(1'b1, 32'h910, 4'd0, 4'd0, 1'b1, 32'hDEAD, 4'd0);
    read_reg("R8 tag write ignored", 4'd0, '0, 1'b0);
    do_wb(1'b1, 32'h920, 4'd0, 4'd0, 1'b0, 32'h5, 4'd10);
    read_reg("R8 source zero clean", 4'd10, 32'h5, 1'b0);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    wb_spec = 1'b1; wb_pc = 32'hA00; wb_src_a = '0; wb_src_b = '0;
    wb_fault = 1'b0; wb_result = 32'h7777; wb_dst = 4'd8; wb_valid = 1'b1;
    rd_a_idx = 4'd8; rd_b_idx = 4'd0;
    #1;
    check("R9 forward data A", {31'd0, rd_a_tag, rd_a_data}, {31'd0, 1'b0, 32'h7777});
    check("R9 no forward r0", {31'd0, rd_b_tag, rd_b_data}, 64'd0);
    @(negedge clk);
    wb_fault = 1'b1; wb_pc = 32'hA10; wb_dst = 4'd9; rd_b_idx = 4'd9;
    #1;
    check("R9 forward tag B", {31'd0, rd_b_tag, rd_b_data}, {31'd0, 1'b1, 32'hA10});
    @(negedge clk);
    wb_valid = 1'b0;
    read_reg("R9 stored", 4'd8, 32'h7777, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_spec_clean();
    t_nonspec_clean();
    t_spec_fault();
    t_propagate();
    t_priority();
    t_nonspec_tagged();
    t_nonspec_fault();
    t_clear_tag();
    t_reg0();
    t_bypass();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule